// File: doc/BRIEF.md
# Programmable-Tap Galois Pseudo-Random Generator

This block produces a pseudo-random sequence of N-bit words from a shift register whose feedback is applied inside the chain (Galois form). When the feedback is active, the top stage's bit is XORed into each stage selected by a run-time coefficient vector. Software or surrounding logic picks the polynomial through the `coef` input, loads a starting value through a seed strobe, and advances the sequence one state per enabled clock.

Two guard features make the generator safe to use with any seed or coefficient set. The all-zero word is a fixed point of XOR feedback, so the block never lets it into the register. A zero seed, or a step that would land on zero, loads the all-ones word instead and raises a one-cycle lockup flag. A period pulse marks each return of the sequence to the value most recently loaded, so a maximal-length polynomial produces one pulse every 2^N-1 steps.

Top module: `prog_galois_lfsr`

## Requirements
- R1: During and after a synchronous reset (`rst` high), the state reads all ones, and `period_done` and `lock_flag` read 0.
- R2: A step maps state s to s' with f = s[N-1] AND coef[N]: s'[0] = coef[0] AND f, and s'[k] = s[k-1] XOR (coef[k] AND f) for 1 ≤ k ≤ N-1. The new state is visible on the clock edge that performs the step.
- R3: With `en` low and `seed_ld` low, the state holds its value.
- R4: When `seed_ld` is high, the state takes `seed_val` on that edge whatever the level of `en`. The load takes priority over stepping, and a load is not counted as a step.
- R5: Loading a zero `seed_val` puts all ones in the state and sets `lock_flag` for exactly the following cycle.
- R6: A step whose result would be all zeros puts all ones in the state instead and sets `lock_flag` for one cycle.
- R7: `period_done` is high for one cycle after a step whose resulting state equals the reference value. The reference value is the word last written by a load (all ones after reset or after a zero seed).
- R8: With N=3 and coef=4'b1011, starting from 111 the state runs 101, 001, 010, 100, 011, 110 and then returns to 111, where `period_done` pulses.
- R9: With N=8 and coef=9'h11D, from any nonzero seed the state visits 255 distinct values, and `period_done` first pulses on the 255th step.
- R10: The state is never all zeros outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the sequence by one state |
| seed_ld | input | 1 | Load `seed_val`; overrides `en` |
| seed_val | input | WIDTH | Starting value to load |
| coef | input | WIDTH+1 | Feedback coefficients, bit k = g[k] |
| state_q | output | WIDTH | Current register state |
| period_done | output | 1 | One-cycle pulse when a step reaches the reference value |
| lock_flag | output | 1 | One-cycle pulse when all ones replaced a zero word |

## Verification
The assertions assume that `coef` is steady on the clock edge at which a step happens, and that every input is a known 0 or 1 once reset is released. The bench changes all inputs only on the falling edge and never leaves them undriven. Random coefficient vectors, including ones with a cleared top bit, are allowed on purpose so that the zero guard is reached. Seeds include zero often enough that the load path's lockup handling is exercised.

// File: rtl/pglfsr_pkg.sv
package pglfsr_pkg;

  // Where the next register value comes from on a given edge
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SEED = 2'd1,
    SRC_STEP = 2'd2
  } src_e;

endpackage

// File: rtl/pglfsr_step.sv
module pglfsr_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH:0]   coef,
  output logic [WIDTH-1:0] nxt,
  output logic             fb
);

  // Feedback bit: top stage gated by the highest coefficient
  function automatic logic feedback_bit(input logic [WIDTH-1:0] s,
                                        input logic [WIDTH:0]   g);
    return s[WIDTH-1] & g[WIDTH];
  endfunction

  assign fb     = feedback_bit(cur, coef);
  assign nxt[0] = coef[0] & fb;

  genvar k;
  generate
    for (k = 1; k < WIDTH; k++) begin : g_stage
      assign nxt[k] = cur[k-1] ^ (coef[k] & fb);
    end
  endgenerate

endmodule

// File: rtl/pglfsr_guard.sv
module pglfsr_guard
  import pglfsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic             seed_ld,
  input  logic [WIDTH-1:0] seed_val,
  input  logic [WIDTH-1:0] stepped,
  output src_e             src,
  output logic [WIDTH-1:0] load_val,
  output logic             lock_evt
);

  localparam logic [WIDTH-1:0] SAFE_WORD = '1;

  logic [WIDTH-1:0] cand;
  logic             cand_zero;

  function automatic logic is_zero(input logic [WIDTH-1:0] v);
    return ~|v;
  endfunction

  always_comb begin
    if (seed_ld)  src = SRC_SEED;
    else if (en)  src = SRC_STEP;
    else          src = SRC_HOLD;
  end

  assign cand      = (src == SRC_SEED) ? seed_val : stepped;
  assign cand_zero = is_zero(cand);
  assign load_val  = cand_zero ? SAFE_WORD : cand;
  assign lock_evt  = (src != SRC_HOLD) && cand_zero;

endmodule

// File: rtl/pglfsr_period.sv
module pglfsr_period
  import pglfsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  src_e             src,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] cur_state,
  output logic             done
);

  logic [WIDTH-1:0] ref_q;
  logic             hit;

  assign hit = (src == SRC_STEP) && (load_val == ref_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '1;
      done  <= 1'b0;
    end else begin
      if (src == SRC_SEED) ref_q <= load_val;
      done <= hit;
    end
  end

  // R7: a pulse only ever appears while the state sits on the reference
  a_r7_done_on_ref: assert property (@(posedge clk) disable iff (rst)
    done |-> (cur_state == ref_q));

endmodule

// File: rtl/prog_galois_lfsr.sv
module prog_galois_lfsr
  import pglfsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             seed_ld,
  input  logic [WIDTH-1:0] seed_val,
  input  logic [WIDTH:0]   coef,
  output logic [WIDTH-1:0] state_q,
  output logic             period_done,
  output logic             lock_flag
);

  localparam logic [WIDTH-1:0] RESET_WORD = '1;

  logic [WIDTH-1:0] stepped;
  logic             fb_bit;
  src_e             src;
  logic [WIDTH-1:0] load_val;
  logic             lock_evt;

  pglfsr_step #(.WIDTH(WIDTH)) u_step (
    .cur  (state_q),
    .coef (coef),
    .nxt  (stepped),
    .fb   (fb_bit)
  );

  pglfsr_guard #(.WIDTH(WIDTH)) u_guard (
    .en       (en),
    .seed_ld  (seed_ld),
    .seed_val (seed_val),
    .stepped  (stepped),
    .src      (src),
    .load_val (load_val),
    .lock_evt (lock_evt)
  );

  pglfsr_period #(.WIDTH(WIDTH)) u_period (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .load_val  (load_val),
    .cur_state (state_q),
    .done      (period_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RESET_WORD;
      lock_flag <= 1'b0;
    end else begin
      if (src != SRC_HOLD) state_q <= load_val;
      lock_flag <= lock_evt;
    end
  end

  // R10: zero never reaches the register
  a_r10_never_zero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R3: idle cycles leave the state alone
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_ld) |=> (state_q == $past(state_q)));

  // R4: a nonzero seed lands verbatim and raises no flag
  a_r4_seed_load: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && (seed_val != '0)) |=> (state_q == $past(seed_val)) && !lock_flag);

  // R5: a zero seed is replaced and flagged
  a_r5_zero_seed: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && (seed_val == '0)) |=> lock_flag && (state_q == RESET_WORD));

  // R6: the flag only accompanies the substituted word
  a_r6_lock_word: assert property (@(posedge clk) disable iff (rst)
    lock_flag |-> (state_q == RESET_WORD));

  // R6: the flag lasts one cycle when the register idles afterwards
  a_r6_lock_pulse: assert property (@(posedge clk) disable iff (rst)
    (lock_flag && !en && !seed_ld) |=> !lock_flag);

endmodule

// File: tb/prog_galois_lfsr_tb.sv
module prog_galois_lfsr_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  // 8-bit instance
  logic       en8 = 0, ld8 = 0;
  logic [7:0] seed8 = 0;
  logic [8:0] coef8 = 0;
  logic [7:0] st8;
  logic       done8, lock8;

  // 3-bit instance
  logic       en3 = 0, ld3 = 0;
  logic [2:0] seed3 = 0;
  logic [3:0] coef3 = 0;
  logic [2:0] st3;
  logic       done3, lock3;

  prog_galois_lfsr #(.WIDTH(8)) u_dut (
    .clk(clk), .rst(rst), .en(en8), .seed_ld(ld8), .seed_val(seed8),
    .coef(coef8), .state_q(st8), .period_done(done8), .lock_flag(lock8));

  prog_galois_lfsr #(.WIDTH(3)) u_dut_w3 (
    .clk(clk), .rst(rst), .en(en3), .seed_ld(ld3), .seed_val(seed3),
    .coef(coef3), .state_q(st3), .period_done(done3), .lock_flag(lock3));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state
  int m8_s = 255, m8_ref = 255, m8_dn = 0, m8_lk = 0;
  int m3_s = 7,   m3_ref = 7,   m3_dn = 0, m3_lk = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Polynomial view: multiply by x, reduce by coefficient word when top set
  function automatic int poly_mul_x(input int s, input int g, input int w);
    int mask = (1 << w) - 1;
    int r = (s << 1) & mask;
    if (((s >> (w-1)) & 1) == 1 && ((g >> w) & 1) == 1) r = r ^ (g & mask);
    return r;
  endfunction

  function automatic void model(input int w, input bit e, input bit l,
                                input int sv, input int cf,
                                inout int s, inout int rf,
                                output int dn, output int lk);
    int ones = (1 << w) - 1;
    int n;
    dn = 0; lk = 0;
    if (l) begin
      if (sv == 0) begin s = ones; lk = 1; end
      else s = sv;
      rf = s;
    end else if (e) begin
      n = poly_mul_x(s, cf, w);
      if (n == 0) begin n = ones; lk = 1; end
      dn = (n == rf) ? 1 : 0;
      s = n;
    end
  endfunction

  task automatic op8(input bit e, input bit l, input int sv, input int cf);
    @(negedge clk);
    en8 = e; ld8 = l; seed8 = sv[7:0]; coef8 = cf[8:0];
    model(8, e, l, sv & 255, cf & 511, m8_s, m8_ref, m8_dn, m8_lk);
    @(posedge clk); #1;
    check("R2 state8", int'(st8), m8_s);
    check("R7 done8", int'(done8), m8_dn);
    check("R6 lock8", int'(lock8), m8_lk);
  endtask

  task automatic op3(input bit e, input bit l, input int sv, input int cf);
    @(negedge clk);
    en3 = e; ld3 = l; seed3 = sv[2:0]; coef3 = cf[3:0];
    model(3, e, l, sv & 7, cf & 15, m3_s, m3_ref, m3_dn, m3_lk);
    @(posedge clk); #1;
    check("R2 state3", int'(st3), m3_s);
    check("R7 done3", int'(done3), m3_dn);
    check("R6 lock3", int'(lock3), m3_lk);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int seq3 [7] = '{5, 1, 2, 4, 3, 6, 7};
    bit seen [256];
    int first_done;
    void'($urandom(32'h5eed_1234));

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 state8", int'(st8), 255);
    check("R1 done8", int'(done8), 0);
    check("R1 lock8", int'(lock8), 0);
    check("R1 state3", int'(st3), 7);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check("R1 state8 after release", int'(st8), 255);

    // R8: three-stage example sequence
    op3(0, 1, 7, 4'b1011);
    for (int i = 0; i < 7; i++) begin
      op3(1, 0, 0, 4'b1011);
      check("R8 sequence", int'(st3), seq3[i]);
    end
    check("R8 period pulse", int'(done3), 1);

    // R3: hold while idle, coefficients wiggling
    op8(0, 1, 8'h5A, 9'h11D);
    for (int i = 0; i < 4; i++) begin
      op8(0, 0, 0, int'($urandom_range(0, 511)));
      check("R3 hold", int'(st8), 8'h5A);
    end

    // R4: load beats enable
    op8(1, 1, 8'hC3, 9'h11D);
    check("R4 load with en", int'(st8), 8'hC3);
    op8(0, 1, 8'h01, 9'h11D);
    check("R4 load without en", int'(st8), 8'h01);

    // R5: zero seed
    op8(1, 1, 0, 9'h11D);
    check("R5 zero seed word", int'(st8), 255);
    check("R5 zero seed flag", int'(lock8), 1);
    op8(0, 0, 0, 9'h11D);
    check("R5 flag one cycle", int'(lock8), 0);

    // R6: step into zero
    op8(0, 1, 8'h80, 9'h100);
    op8(1, 0, 0, 9'h100);
    check("R6 guarded word", int'(st8), 255);
    check("R6 guarded flag", int'(lock8), 1);
    op8(0, 0, 0, 9'h100);
    check("R6 flag clears", int'(lock8), 0);

    // R9: maximal 8-bit polynomial
    op8(0, 1, 8'h01, 9'h11D);
    foreach (seen[i]) seen[i] = 0;
    seen[1] = 1;
    first_done = 0;
    for (int i = 1; i <= 255; i++) begin
      op8(1, 0, 0, 9'h11D);
      if (done8 && first_done == 0) first_done = i;
      if (i < 255) begin
        check("R9 no repeat", int'(seen[st8]), 0);
        check("R10 nonzero", int'(st8 != 0), 1);
        seen[st8] = 1;
      end
    end
    check("R9 period length", first_done, 255);
    check("R9 back to seed", int'(st8), 1);

    // Random mix: seeds (some zero), coefficient sets, enable patterns
    for (int i = 0; i < 400; i++) begin
      bit e = ($urandom_range(0, 3) != 0);
      bit l = ($urandom_range(0, 15) == 0);
      int sv = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 255));
      int cf = ($urandom_range(0, 1) == 0) ? 9'h11D : int'($urandom_range(0, 511));
      op8(e, l, sv, cf);
      check("R10 random nonzero", int'(st8 != 0), 1);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule